// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Logic

This block is the status and interrupt section of a UART whose receive and transmit paths each hold up to 16 bytes. It does not store the data bytes. It takes the push and pop strobes of both queues and, for every received character, a set of three error flags: parity, framing and break. From these it tracks both fill levels and keeps a per-entry copy of the receive error flags. It also builds the eight-bit line status word, applies the interrupt enable mask, and drives one active-high interrupt line.

A small host register port gives access to four registers. They are the interrupt enable register, the queue control register, the line status word and an interrupt pending summary. In queued mode the receive and transmit conditions follow programmable thresholds. In single-entry mode each direction holds one character. With the queues enabled and the low four enable bits cleared, the host polls the line status word and the interrupt line stays low.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset the enable register reads 0x00, the queue control register reads 0x00, the pending summary reads 0x00, `irq` is low and the line status word reads 0x60.
- R2: Line status bit 0 is 1 exactly while the receive queue holds at least one character; it sets on the clock edge that accepts a push and clears when the queue becomes empty.
- R3: A push arriving while the receive queue is at capacity, with no pop in the same cycle, is discarded and sets line status bit 1; that bit stays set until a line status read (a `reg_rd` strobe at address 2) and is not cleared by a receive reset.
- R4: Line status bits 2, 3 and 4 show the parity, framing and break flags (`rx_err` bits 0, 1 and 2) of the character at the head of the receive queue, and read 0 when the queue is empty.
- R5: Line status bit 7 is 1 while any character in the receive queue carries a nonzero flag; a line status read clears the head entry's flags, so bit 7 then stays set only if other errored characters remain.
- R6: Line status bit 5 is 1 while the transmit queue is empty; bit 6 is 1 while the transmit queue is empty and `tx_shift_busy` is low.
- R7: Queue control bits 7:6 pick the receive threshold (00 = 1, 01 = 4, 10 = 8, 11 = 14); with enable bit 0 set, pending bit 0 is 1 while the receive level is at or above that threshold in queued mode, or at least 1 in single-entry mode, and clears once the level falls below it.
- R8: Queue control bits 5:4 pick the transmit threshold (00 = 1, 01 = 4, 10 = 8, 11 = 12); with enable bit 1 set, pending bit 1 is 1 while the transmit level is below that threshold in queued mode, or zero in single-entry mode, so enabling it with an empty transmit queue raises `irq` on the next cycle.
- R9: With enable bit 2 set, pending bit 2 is 1 while line status bit 1 is set or the head entry has a nonzero flag.
- R10: `irq` is the OR of pending bits 2:0; with queue control bit 0 set and enable bits 3:0 all zero, `irq` stays low while the line status word still reports every condition.
- R11: A queue control write with bit 1 set empties the receive queue and its error flags, and with bit 2 set empties the transmit queue, in one clock; a write that changes bit 0 empties both queues.
- R12: With queue control bit 0 clear, each queue holds one character, so a second push without a pop is refused.
- R13: Address 0 reads back enable bits 3:0 with bits 7:4 as 0; address 1 reads back bits 7:4 and bit 0 of the last control write with bits 3:1 as 0; address 3 reads the pending bits in 2:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | A received character completes and enters the receive queue |
| rx_err | input | 3 | Error flags of the pushed character: bit 0 parity, bit 1 framing, bit 2 break |
| rx_pop | input | 1 | Host takes the head character from the receive queue |
| tx_push | input | 1 | Host writes a character into the transmit queue |
| tx_pop | input | 1 | Transmitter moves the head character into its shift register |
| tx_shift_busy | input | 1 | The transmit shift register is still sending |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 2 it clears the read-sensitive status |
| reg_addr | input | 2 | Register select: 0 enable, 1 queue control, 2 line status, 3 pending summary |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data of the selected address |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default depth of 16. That depth lets every receive threshold up to 14 be reached, lets a full queue overrun in queued mode, and makes single-entry mode reachable by clearing the queue enable bit. Directed sequences cover each threshold edge, the interrupt that appears at once when transmit interrupts are enabled, the clearing of the head flags by a status read, and both queue resets. A long seeded random run then mixes same-cycle push, pop, status read and register writes. It compares every register and the interrupt line against a queue model kept in the bench.

// File: rtl/ufs_pkg.sv
`timescale 1ns/1ps
package ufs_pkg;

    typedef enum logic [1:0] {
        A_ENABLE = 2'd0,
        A_FCTRL  = 2'd1,
        A_LSTAT  = 2'd2,
        A_IPEND  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [3:0] ier;
        logic       fen;
        logic [1:0] rtc;
        logic [1:0] ttc;
        logic       ovr;
    } ctl_t;

    // receive threshold per two-bit code
    function automatic logic [4:0] rx_trig_val(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    // transmit threshold per two-bit code
    function automatic logic [4:0] tx_trig_val(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd12;
        endcase
    endfunction

endpackage

// File: rtl/ufs_level.sv
`timescale 1ns/1ps
module ufs_level #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clr,
    input  logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] lvl,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             refused
);

    typedef struct packed {
        logic [CNT_W-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !clr && (st_q.lvl != '0);
        push_ok = push && !clr && ((st_q.lvl < cap) || pop_ok);
        refused = push && !clr && !push_ok;
        if (clr) begin
            st_d.lvl = '0;
        end else begin
            st_d.lvl = st_q.lvl + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;

endmodule

// File: rtl/ufs_rx_errs.sv
`timescale 1ns/1ps
module ufs_rx_errs #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push_ok,
    input  logic       pop_ok,
    input  logic       clr_head,
    input  logic       nonempty,
    input  logic [2:0] err_in,
    output logic [2:0] head_err,
    output logic       any_err
);

    typedef struct packed {
        logic [PTR_W-1:0]          wr;
        logic [PTR_W-1:0]          rd;
        logic [DEPTH-1:0][2:0]     mem;
        logic [CNT_W-1:0]          ecnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [2:0] head;
    logic       head_bad, inc, dec;

    always_comb begin
        st_d     = st_q;
        head     = st_q.mem[st_q.rd];
        head_bad = nonempty && (|head);
        dec      = head_bad && (pop_ok || clr_head);
        inc      = push_ok && (|err_in);
        if (clr) begin
            st_d = '0;
        end else begin
            if (clr_head && !pop_ok && nonempty) st_d.mem[st_q.rd] = 3'b000;
            if (pop_ok) st_d.rd = nxt(st_q.rd);
            if (push_ok) begin
                st_d.mem[st_q.wr] = err_in;
                st_d.wr           = nxt(st_q.wr);
            end
            st_d.ecnt = st_q.ecnt + CNT_W'(inc) - CNT_W'(dec);
        end
        head_err = nonempty ? head : 3'b000;
        any_err  = (st_q.ecnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ufs_irq.sv
`timescale 1ns/1ps
module ufs_irq #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [3:0]       ier,
    input  logic             fen,
    input  logic [1:0]       rtc,
    input  logic [1:0]       ttc,
    input  logic [CNT_W-1:0] rx_lvl,
    input  logic [CNT_W-1:0] tx_lvl,
    input  logic             ls_evt,
    output logic [2:0]       pend,
    output logic             irq
);
    import ufs_pkg::*;

    logic rx_hit, tx_hit;

    always_comb begin
        if (fen) begin
            rx_hit = rx_lvl >= CNT_W'(rx_trig_val(rtc));
            tx_hit = tx_lvl <  CNT_W'(tx_trig_val(ttc));
        end else begin
            rx_hit = rx_lvl != '0;
            tx_hit = tx_lvl == '0;
        end
        pend = {ier[2] & ls_evt, ier[1] & tx_hit, ier[0] & rx_hit};
        irq  = |pend;
    end

endmodule

// File: rtl/uart_fifo_status.sv
`timescale 1ns/1ps
module uart_fifo_status #(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [2:0] rx_err,
    input  logic       rx_pop,
    input  logic       tx_push,
    input  logic       tx_pop,
    input  logic       tx_shift_busy,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    import ufs_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    ctl_t st_d, st_q;

    logic             wr_ier, wr_fcr, rd_lsr, fen_chg, rx_clr, tx_clr;
    logic [CNT_W-1:0] cap, rx_lvl, tx_lvl;
    logic             rx_push_ok, rx_pop_ok, rx_refused;
    logic             tx_push_ok, tx_pop_ok, tx_refused;
    logic [2:0]       head_err, pend;
    logic             any_err, tx_empty, ls_evt;
    logic [3:0]       ier_cur;
    logic             fen_cur;
    logic [7:0]       lsr_v;
    logic             unused_bits;

    // host register decode
    always_comb begin
        wr_ier  = reg_wr && (reg_addr == A_ENABLE);
        wr_fcr  = reg_wr && (reg_addr == A_FCTRL);
        rd_lsr  = reg_rd && (reg_addr == A_LSTAT);
        fen_chg = wr_fcr && (reg_wdata[0] != st_q.fen);
        rx_clr  = wr_fcr && (reg_wdata[1] || fen_chg);
        tx_clr  = wr_fcr && (reg_wdata[2] || fen_chg);
        cap     = st_q.fen ? CNT_W'(DEPTH) : CNT_W'(1);
        ier_cur = st_q.ier;
        fen_cur = st_q.fen;
    end

    ufs_level #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .clr(rx_clr),
        .cap(cap), .lvl(rx_lvl), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .refused(rx_refused)
    );

    ufs_level #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .clr(tx_clr),
        .cap(cap), .lvl(tx_lvl), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
        .refused(tx_refused)
    );

    ufs_rx_errs #(.DEPTH(DEPTH)) u_rx_errs (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push_ok(rx_push_ok),
        .pop_ok(rx_pop_ok), .clr_head(rd_lsr), .nonempty(rx_lvl != '0),
        .err_in(rx_err), .head_err(head_err), .any_err(any_err)
    );

    ufs_irq #(.DEPTH(DEPTH)) u_irq (
        .ier(ier_cur), .fen(fen_cur), .rtc(st_q.rtc), .ttc(st_q.ttc),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .ls_evt(ls_evt), .pend(pend), .irq(irq)
    );

    // next-state of control registers and overrun flag
    always_comb begin
        st_d = st_q;
        if (wr_ier) st_d.ier = reg_wdata[3:0];
        if (wr_fcr) begin
            st_d.fen = reg_wdata[0];
            st_d.ttc = reg_wdata[5:4];
            st_d.rtc = reg_wdata[7:6];
        end
        st_d.ovr = rx_refused | (st_q.ovr & ~rd_lsr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // line status word and read mux
    always_comb begin
        tx_empty = (tx_lvl == '0);
        ls_evt   = st_q.ovr | (|head_err);
        lsr_v    = {any_err, tx_empty & ~tx_shift_busy, tx_empty, head_err,
                    st_q.ovr, rx_lvl != '0};
        case (reg_addr)
            A_ENABLE: reg_rdata = {4'b0000, st_q.ier};
            A_FCTRL:  reg_rdata = {st_q.rtc, st_q.ttc, 3'b000, st_q.fen};
            A_LSTAT:  reg_rdata = lsr_v;
            default:  reg_rdata = {5'b00000, pend};
        endcase
    end

    assign unused_bits = ^{tx_push_ok, tx_pop_ok, tx_refused, reg_wdata[3]};

endmodule

// File: rtl/ufs_status_chk.sv
`timescale 1ns/1ps
module ufs_status_chk #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic             wbit1,
    input logic [7:0]       lsr,
    input logic             irq,
    input logic [3:0]       ier,
    input logic             fen,
    input logic [CNT_W-1:0] rx_lvl,
    input logic [CNT_W-1:0] tx_lvl,
    input logic [CNT_W-1:0] cap
);

    p_rx_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lsr[0]) |-> $past(rx_push));

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && (rx_lvl == cap) && !(reg_wr && reg_addr == 2'd1))
        |=> lsr[1]);

    p_overrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[1] && !(reg_rd && reg_addr == 2'd2)) |=> lsr[1]);

    p_head_err_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|lsr[4:2]) |-> lsr[7]);

    p_tx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    p_tx_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ier[1]) && (tx_lvl == '0)) |-> irq);

    p_polled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fen && (ier == 4'd0)) |-> !irq);

    p_rx_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd1) && wbit1) |=> (!lsr[0] && !lsr[7]));

endmodule

bind uart_fifo_status ufs_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .wbit1(reg_wdata[1]),
    .lsr(lsr_v), .irq(irq), .ier(ier_cur), .fen(fen_cur),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .cap(cap)
);

// File: tb/tb_uart_fifo_status.sv
`timescale 1ns/1ps
module tb_uart_fifo_status;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, tx_shift_busy = 0;
    logic [2:0] rx_err = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq;

    uart_fifo_status #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_err(rx_err),
        .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .tx_shift_busy(tx_shift_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the requirements
    logic [2:0] mq[$];
    bit         movr = 0;
    int         mtx = 0;
    logic [3:0] mier = 0;
    bit         mfen = 0;
    logic [1:0] mrtc = 0, mttc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rtrig(input logic [1:0] c);
        case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
    endfunction

    function automatic int ttrig(input logic [1:0] c);
        case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 12; endcase
    endfunction

    function automatic logic [7:0] exp_lsr();
        logic [7:0] v;
        v = '0;
        v[0] = mq.size() > 0;
        v[1] = movr;
        if (mq.size() > 0) v[4:2] = mq[0];
        v[5] = (mtx == 0);
        v[6] = (mtx == 0) && !tx_shift_busy;
        foreach (mq[i]) if (mq[i] != 3'b000) v[7] = 1'b1;
        return v;
    endfunction

    function automatic logic [2:0] exp_pend();
        logic rxh, txh, lsh;
        rxh = mfen ? (mq.size() >= rtrig(mrtc)) : (mq.size() > 0);
        txh = mfen ? (mtx < ttrig(mttc)) : (mtx == 0);
        lsh = movr || ((mq.size() > 0) && (mq[0] != 3'b000));
        return {mier[2] & lsh, mier[1] & txh, mier[0] & rxh};
    endfunction

    function automatic logic [7:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0:    return {4'b0000, mier};
            2'd1:    return {mrtc, mttc, 3'b000, mfen};
            2'd2:    return exp_lsr();
            default: return {5'b00000, exp_pend()};
        endcase
    endfunction

    task automatic model_step();
        bit rd_l, fchg, rclr, tclr, popok, full, ovf, tpop;
        int cap, tpre;
        cap  = mfen ? DEPTH : 1;
        rd_l = reg_rd && (reg_addr == 2'd2);
        fchg = reg_wr && (reg_addr == 2'd1) && (reg_wdata[0] != mfen);
        rclr = reg_wr && (reg_addr == 2'd1) && (reg_wdata[1] || fchg);
        tclr = reg_wr && (reg_addr == 2'd1) && (reg_wdata[2] || fchg);
        ovf  = 0;
        if (rclr) mq.delete();
        else begin
            popok = rx_pop && (mq.size() > 0);
            if (rd_l && !popok && mq.size() > 0) mq[0] = 3'b000;
            full = mq.size() >= cap;
            if (popok) void'(mq.pop_front());
            if (rx_push) begin
                if (!full || popok) mq.push_back(rx_err);
                else ovf = 1;
            end
        end
        movr = ovf || (movr && !rd_l);
        if (tclr) mtx = 0;
        else begin
            tpre = mtx;
            tpop = tx_pop && (tpre > 0);
            if (tpop) mtx--;
            if (tx_push && (tpre < cap || tpop)) mtx++;
        end
        if (reg_wr && reg_addr == 2'd0) mier = reg_wdata[3:0];
        if (reg_wr && reg_addr == 2'd1) begin
            mfen = reg_wdata[0];
            mttc = reg_wdata[5:4];
            mrtc = reg_wdata[7:6];
        end
    endtask

    // inputs are set just after a negedge; this checks, advances the model
    // across the coming posedge and clears the strobes at the next negedge
    task automatic tick();
        string t;
        #1;
        case (reg_addr)
            2'd0: t = "R13 enable readback";
            2'd1: t = "R13 control readback";
            2'd2: t = "R2/R4/R5/R6 line status";
            default: t = "R7/R8/R9 pending";
        endcase
        chk(t, reg_rdata, exp_reg(reg_addr));
        chk("R10 irq", irq, |exp_pend());
        model_step();
        @(negedge clk);
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rxp(input logic [2:0] e); rx_push = 1; rx_err = e; tick(); endtask
    task automatic rxo(); rx_pop = 1; tick(); endtask
    task automatic txp(); tx_push = 1; tick(); endtask
    task automatic txo(); tx_pop = 1; tick(); endtask
    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask
    task automatic rdlsr(); reg_rd = 1; reg_addr = 2'd2; tick(); endtask

    initial begin
        int n;
        n = 0;
        while (!finished && n < 200000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", n);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1550));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd2, v); chk("R1 lsr", v, 8'h60);
        peek(2'd0, v); chk("R1 enable", v, 8'h00);
        peek(2'd1, v); chk("R1 control", v, 8'h00);
        peek(2'd3, v); chk("R1 pending", v, 8'h00);
        chk("R1 irq", irq, 0);

        // R12 single-entry mode
        rxp(3'b000);
        peek(2'd2, v); chk("R2 ready set", v[0], 1);
        rxp(3'b000);
        peek(2'd2, v); chk("R12/R3 second push refused", v, 8'h63);
        rdlsr();
        peek(2'd2, v); chk("R3 overrun cleared by read", v, 8'h61);
        rxo();
        peek(2'd2, v); chk("R2 ready clear", v, 8'h60);
        wreg(2'd0, 8'h02);
        chk("R8 enable with empty tx", irq, 1);
        peek(2'd3, v); chk("R8 pending", v, 8'h02);
        txp();
        chk("R8 holding full", irq, 0);
        peek(2'd2, v); chk("R6 tx not empty", v, 8'h00);
        txp();
        txo();
        chk("R12 tx one entry", irq, 1);
        tx_shift_busy = 1;
        peek(2'd2, v); chk("R6 shift busy", v, 8'h20);
        tx_shift_busy = 0;

        // R11 changing the queue enable empties both queues
        rxp(3'b000);
        wreg(2'd1, 8'h81);
        peek(2'd2, v); chk("R11 enable change clears", v[0], 0);
        peek(2'd1, v); chk("R13 control", v, 8'h81);

        // R7 threshold 8
        wreg(2'd0, 8'h01);
        repeat (7) rxp(3'b000);
        chk("R7 below eight", irq, 0);
        rxp(3'b000);
        chk("R7 at eight", irq, 1);
        peek(2'd3, v); chk("R7 pending", v, 8'h01);
        rxo();
        chk("R7 back below", irq, 0);

        // R5 / R4 error tracking
        rxp(3'b001);
        peek(2'd2, v); chk("R5 errored entry behind head", v, 8'hE1);
        repeat (7) rxo();
        peek(2'd2, v); chk("R4 parity at head", v, 8'hE5);
        rdlsr();
        peek(2'd2, v); chk("R5 head flags cleared", v, 8'h61);
        rxo();
        for (int i = 0; i < DEPTH; i++) rxp((i == 0) ? 3'b100 : 3'b000);
        peek(2'd2, v); chk("R4 break at head", v, 8'hF1);
        rxp(3'b000);
        peek(2'd2, v); chk("R3 full queue overrun", v, 8'hF3);

        // R9 line status interrupt
        wreg(2'd0, 8'h04);
        chk("R9 overrun irq", irq, 1);
        wreg(2'd1, 8'h83);
        peek(2'd2, v); chk("R11 rx reset keeps overrun", v, 8'h62);
        rdlsr();
        chk("R9 cleared", irq, 0);

        // R8 transmit threshold 4
        wreg(2'd1, 8'h91);
        wreg(2'd0, 8'h02);
        chk("R8 empty below four", irq, 1);
        repeat (3) txp();
        chk("R8 three below four", irq, 1);
        txp();
        chk("R8 at four", irq, 0);
        txo();
        chk("R8 falls below", irq, 1);
        wreg(2'd1, 8'h95);
        peek(2'd2, v); chk("R11 tx reset", v, 8'h60);

        // R10 polled mode
        rxp(3'b010);
        rxp(3'b000);
        wreg(2'd0, 8'h00);
        chk("R10 polled irq low", irq, 0);
        peek(2'd2, v); chk("R10 status still readable", v, 8'hE9);
        wreg(2'd1, 8'h93);

        // R13 readback
        wreg(2'd0, 8'hFF);
        peek(2'd0, v); chk("R13 enable bits", v, 8'h0F);
        wreg(2'd0, 8'h00);

        // R7 threshold 14
        wreg(2'd1, 8'hC1);
        wreg(2'd0, 8'h01);
        repeat (13) rxp(3'b000);
        chk("R7 below fourteen", irq, 0);
        rxp(3'b000);
        chk("R7 at fourteen", irq, 1);
        wreg(2'd1, 8'hC3);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            rx_push = ($urandom_range(99) < 40);
            rx_err  = ($urandom_range(99) < 30) ? 3'($urandom_range(7)) : 3'b000;
            rx_pop  = ($urandom_range(99) < 35);
            tx_push = ($urandom_range(99) < 35);
            tx_pop  = ($urandom_range(99) < 35);
            tx_shift_busy = ($urandom_range(99) < 50);
            reg_addr = 2'($urandom_range(3));
            if ($urandom_range(99) < 6) begin
                reg_rd = 1;
                reg_addr = 2'd2;
            end else if ($urandom_range(99) < 3) begin
                reg_wr = 1;
                reg_addr = 2'd0;
                reg_wdata = 8'($urandom_range(255));
            end else if ($urandom_range(199) < 2) begin
                reg_wr = 1;
                reg_addr = 2'd1;
                reg_wdata = 8'($urandom_range(255));
                if ($urandom_range(3) != 0) reg_wdata[0] = mfen;
            end
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule